// File: doc/BRIEF.md
# Temperature Excursion Interrupt Tracker

This block watches a set of temperature channels (by default one on-die and one remote sensor) against a programmable high and low soft limit per channel. On each conversion-done strobe every channel's reading is compared with its two limits using signed 8-bit arithmetic. A reading outside a limit sets a sticky status bit. The status bits stay set until the status register is read, and a read clears them.

The interrupt request to the system aggregator is raised once per excursion, not once per conversion. Each channel has an armed flag and a one-bit record of which limit disarmed it. An armed channel whose reading leaves its limits raises the request. It then disarms and records the limit it crossed. While the reading stays past that same limit, later conversions set the status bit again but raise no request. The channel fires again in three cases: the reading leaves through the opposite limit; the recorded limit is rewritten and a later reading lies outside it; or any other interrupt source fires. The last case covers an external event input and a firing of any other temperature channel.

The analog converter and the register bus are outside this block. It receives the strobes and values already decoded and returns status bits and one request line.

Top module: `tet_tracker`

## Requirements
- R1: On a conversion strobe, a channel reading strictly greater than its high limit (signed compare; equal does not count) sets status bit 2c. If the channel is armed, or is disarmed with a low-limit record, and mask bit 2c is 0, `irq_o` reads 1 in the following cycle.
- R2: On a conversion strobe, a reading strictly less than the low limit (signed) sets status bit 2c+1. If the channel is armed, or is disarmed with a high-limit record, and mask bit 2c+1 is 0, the request is raised in the following cycle.
- R3: A status read pulse clears all status bits and drops `irq_o` in the following cycle, unless a conversion in the same cycle sets them again.
- R4: After a channel raises the request it is disarmed. Later readings past the same limit set the status bit again but do not raise the request.
- R5: A disarmed channel raises the request again when a reading crosses the opposite limit from the one recorded.
- R6: Writing the recorded limit of a disarmed channel re-arms it, so the next out-of-limit reading raises the request. Writing the other limit does not re-arm it.
- R7: A pulse on `other_irq_i`, or a firing of another channel, re-arms every channel. A channel's own firing in the same cycle keeps that channel disarmed.
- R8: A masked excursion sets its status bit but neither raises the request nor disarms the channel.
- R9: When a conversion and a status read fall in the same cycle, the sets from the conversion win over the clear.
- R10: After reset, the status bits and `irq_o` are 0, every channel is armed, and the limits are at their reset values: high +127 and low -128, so no reading trips.
- R11: A limit write takes effect for conversions after its cycle. A conversion in the same cycle compares against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done_i | input | 1 | Conversion-complete strobe |
| temp_i | input | NUM_CH*8 | Signed readings, channel c in bits [8c+7:8c] |
| lim_wr_i | input | 1 | Limit write strobe |
| lim_sel_i | input | SEL_W | Channel being written |
| lim_is_hi_i | input | 1 | 1 writes the high limit, 0 the low limit |
| lim_data_i | input | 8 | Signed limit value |
| sts_rd_i | input | 1 | Status read pulse (clear on read) |
| other_irq_i | input | 1 | Some other interrupt source fired |
| mask_i | input | 2*NUM_CH | Bit 2c masks high excursions, bit 2c+1 low excursions of channel c |
| sts_o | output | 2*NUM_CH | Sticky status, bit 2c high, bit 2c+1 low |
| irq_o | output | 1 | Interrupt request to the aggregator |

## Verification
Two collisions can occur in one cycle. A status read can coincide with a conversion that sets status bits again. A limit write, or the firing of another channel, can coincide with a conversion that disarms the channel being re-armed. The bench provokes both with directed cycles that place the read or write on the same edge as an out-of-limit conversion. Random traffic also drives all strobes independently. In every cycle the status vector and request are compared with a bench model that applies the stated precedence: set over clear, and disarm over re-arm.

// File: rtl/tet_pkg.sv
package tet_pkg;
  localparam int TEMP_W = 8;
  typedef logic signed [TEMP_W-1:0] temp_t;

  function automatic logic temp_above(input temp_t v, input temp_t lim);
    return v > lim;
  endfunction

  function automatic logic temp_below(input temp_t v, input temp_t lim);
    return v < lim;
  endfunction
endpackage

// File: rtl/tet_limits.sv
module tet_limits
  import tet_pkg::*;
#(
  parameter int    NUM_CH = 2,
  parameter int    SEL_W  = 1,
  parameter temp_t RST_HI = 8'sd127,
  parameter temp_t RST_LO = -8'sd128
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             is_hi_i,
  input  temp_t            data_i,
  output temp_t            hi_o    [NUM_CH],
  output temp_t            lo_o    [NUM_CH],
  output logic             hit_hi_o[NUM_CH],
  output logic             hit_lo_o[NUM_CH]
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    temp_t hi_q, lo_q;
    logic  sel_c;
    assign sel_c       = wr_i && (sel_i == SEL_W'(c));
    assign hit_hi_o[c] = sel_c && is_hi_i;
    assign hit_lo_o[c] = sel_c && !is_hi_i;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q <= RST_HI;
        lo_q <= RST_LO;
      end else begin
        if (hit_hi_o[c]) hi_q <= data_i;
        if (hit_lo_o[c]) lo_q <= data_i;
      end
    end
    assign hi_o[c] = hi_q;
    assign lo_o[c] = lo_q;

    a_r11_hi_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel_i == SEL_W'(c) && is_hi_i) |=> hi_q == $past(data_i));
    a_r11_lo_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel_i == SEL_W'(c) && !is_hi_i) |=> lo_q == $past(data_i));
  end
endmodule

// File: rtl/tet_chan.sv
module tet_chan
  import tet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_i,
  input  temp_t      temp_i,
  input  temp_t      hi_i,
  input  temp_t      lo_i,
  input  logic [1:0] mask_i,     // [0] high, [1] low
  input  logic       wr_hi_i,
  input  logic       wr_lo_i,
  input  logic       ext_arm_i,
  input  logic       clr_i,
  output logic [1:0] sts_o,      // [0] high, [1] low
  output logic       fire_o
);
  logic armed_q, rec_hi_q, sts_hi_q, sts_lo_q;
  logic over_w, under_w, fire_hi_w, fire_lo_w, rearm_w;

  assign over_w  = temp_above(temp_i, hi_i);
  assign under_w = temp_below(temp_i, lo_i);

  // allowed when armed, or when crossing the limit opposite the record
  assign fire_hi_w = conv_i && over_w  && !mask_i[0] && (armed_q || !rec_hi_q);
  assign fire_lo_w = conv_i && under_w && !mask_i[1] && (armed_q ||  rec_hi_q);
  assign fire_o    = fire_hi_w || fire_lo_w;

  assign rearm_w = ext_arm_i || (wr_hi_i && rec_hi_q) || (wr_lo_i && !rec_hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b1;
      rec_hi_q <= 1'b0;
      sts_hi_q <= 1'b0;
      sts_lo_q <= 1'b0;
    end else begin
      if (fire_o)       armed_q <= 1'b0;
      else if (rearm_w) armed_q <= 1'b1;

      if (fire_hi_w)      rec_hi_q <= 1'b1;
      else if (fire_lo_w) rec_hi_q <= 1'b0;

      if (conv_i && over_w)  sts_hi_q <= 1'b1;
      else if (clr_i)        sts_hi_q <= 1'b0;
      if (conv_i && under_w) sts_lo_q <= 1'b1;
      else if (clr_i)        sts_lo_q <= 1'b0;
    end
  end
  assign sts_o = {sts_lo_q, sts_hi_q};

  a_r4_disarm_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !armed_q);
  a_r1_hi_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_i && over_w) |=> sts_hi_q);
  a_r2_lo_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_i && under_w) |=> sts_lo_q);
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == 2'b11) |-> !fire_o);
  a_r8_masked_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mask_i == 2'b11) |=> armed_q);
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && conv_i && over_w) |=> sts_hi_q);
endmodule

// File: rtl/tet_tracker.sv
module tet_tracker
  import tet_pkg::*;
#(
  parameter int    NUM_CH = 2,
  parameter temp_t RST_HI = 8'sd127,
  parameter temp_t RST_LO = -8'sd128,
  localparam int   SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int   STS_W  = 2 * NUM_CH
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       conv_done_i,
  input  logic [NUM_CH*TEMP_W-1:0]   temp_i,
  input  logic                       lim_wr_i,
  input  logic [SEL_W-1:0]           lim_sel_i,
  input  logic                       lim_is_hi_i,
  input  logic [TEMP_W-1:0]          lim_data_i,
  input  logic                       sts_rd_i,
  input  logic                       other_irq_i,
  input  logic [STS_W-1:0]           mask_i,
  output logic [STS_W-1:0]           sts_o,
  output logic                       irq_o
);
  temp_t hi_w[NUM_CH], lo_w[NUM_CH];
  logic  wr_hi_w[NUM_CH], wr_lo_w[NUM_CH];
  logic [NUM_CH-1:0] fire_w;
  logic  any_fire_w, irq_q;

  tet_limits #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .RST_HI(RST_HI), .RST_LO(RST_LO)) lim_i (
    .clk(clk), .rst_n(rst_n), .wr_i(lim_wr_i), .sel_i(lim_sel_i),
    .is_hi_i(lim_is_hi_i), .data_i(temp_t'(lim_data_i)),
    .hi_o(hi_w), .lo_o(lo_w), .hit_hi_o(wr_hi_w), .hit_lo_o(wr_lo_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sib_fire_w;
    assign sib_fire_w = |(fire_w & ~(NUM_CH'(1) << c));
    tet_chan ch_i (
      .clk(clk), .rst_n(rst_n), .conv_i(conv_done_i),
      .temp_i(temp_t'(temp_i[c*TEMP_W +: TEMP_W])),
      .hi_i(hi_w[c]), .lo_i(lo_w[c]), .mask_i(mask_i[2*c +: 2]),
      .wr_hi_i(wr_hi_w[c]), .wr_lo_i(wr_lo_w[c]),
      .ext_arm_i(other_irq_i || sib_fire_w), .clr_i(sts_rd_i),
      .sts_o(sts_o[2*c +: 2]), .fire_o(fire_w[c])
    );
  end

  assign any_fire_w = |fire_w;

  always_ff @(posedge clk) begin
    if (!rst_n)          irq_q <= 1'b0;
    else if (any_fire_w) irq_q <= 1'b1;
    else if (sts_rd_i)   irq_q <= 1'b0;
  end
  assign irq_o = irq_q;

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd_i && !conv_done_i) |=> (sts_o == '0 && !irq_o));
  a_r4_irq_from_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(any_fire_w));
  a_r1_fire_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
    any_fire_w |-> conv_done_i);
  a_r9_fire_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fire_w && sts_rd_i) |=> irq_o);
endmodule

// File: tb/tet_tracker_tb_top.sv
module tet_tracker_tb_top;
  localparam int N = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0, wr = 1'b0, is_hi = 1'b0, rd = 1'b0, oth = 1'b0;
  logic [0:0] sel = '0;
  logic [7:0] data = '0;
  logic [15:0] temps = '0;
  logic [3:0] mask = '0;
  logic [3:0] sts;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic signed [7:0] m_hi[N], m_lo[N];
  bit m_arm[N], m_rec_hi[N];
  logic [3:0] m_sts;
  bit m_irq;

  always #4 clk = ~clk;

  tet_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done_i(conv), .temp_i(temps),
    .lim_wr_i(wr), .lim_sel_i(sel), .lim_is_hi_i(is_hi), .lim_data_i(data),
    .sts_rd_i(rd), .other_irq_i(oth), .mask_i(mask), .sts_o(sts), .irq_o(irq)
  );

  function automatic bit gt8(logic [7:0] a, logic [7:0] b);
    return $signed(a) > $signed(b);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      m_hi[c] = 8'sd127; m_lo[c] = -8'sd128; m_arm[c] = 1; m_rec_hi[c] = 0;
    end
    m_sts = '0; m_irq = 0;
  endtask

  task automatic check(string req);
    checks++;
    if (sts !== m_sts || irq !== m_irq) begin
      failures++;
      $display("FAIL %s: sts=%b irq=%b expected sts=%b irq=%b", req, sts, irq, m_sts, m_irq);
    end
  endtask

  // one clock: drive, advance the model, sample after the edge
  task automatic cyc(bit c_conv, logic [7:0] t0, logic [7:0] t1, bit c_rd, bit c_oth,
                     bit c_wr, int c_sel, bit c_hi, logic [7:0] c_d, string req);
    bit f_hi[N], f_lo[N], fired[N], any;
    logic [7:0] t;
    @(negedge clk);
    conv = c_conv; temps = {t1, t0}; rd = c_rd; oth = c_oth;
    wr = c_wr; sel = 1'(c_sel); is_hi = c_hi; data = c_d;
    any = 0;
    for (int c = 0; c < N; c++) begin
      t = (c == 0) ? t0 : t1;
      f_hi[c] = c_conv && gt8(t, m_hi[c]) && !mask[2*c]   && (m_arm[c] || !m_rec_hi[c]);
      f_lo[c] = c_conv && gt8(m_lo[c], t) && !mask[2*c+1] && (m_arm[c] ||  m_rec_hi[c]);
      fired[c] = f_hi[c] || f_lo[c];
      any |= fired[c];
      // status: conversion set has priority over the read clear (R9)
      if (c_conv && gt8(t, m_hi[c])) m_sts[2*c] = 1; else if (c_rd) m_sts[2*c] = 0;
      if (c_conv && gt8(m_lo[c], t)) m_sts[2*c+1] = 1; else if (c_rd) m_sts[2*c+1] = 0;
    end
    for (int c = 0; c < N; c++) begin
      bit others, wr_rec;
      others = 0;
      for (int k = 0; k < N; k++) if (k != c && fired[k]) others = 1;
      wr_rec = c_wr && c_sel == c && (c_hi == m_rec_hi[c]);
      if (fired[c]) begin
        m_arm[c] = 0; m_rec_hi[c] = f_hi[c];
      end else if (c_oth || others || wr_rec) m_arm[c] = 1;
    end
    if (any) m_irq = 1; else if (c_rd) m_irq = 0;
    if (c_wr) begin
      if (c_hi) m_hi[c_sel] = c_d; else m_lo[c_sel] = c_d;
    end
    @(posedge clk); #2;
    check(req);
  endtask

  task automatic conv2(logic [7:0] t0, logic [7:0] t1, string req);
    cyc(1, t0, t1, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic rdp(string req);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, req);
  endtask
  task automatic wlim(int s, bit h, logic [7:0] d, string req);
    cyc(0, 0, 0, 0, 0, 1, s, h, d, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R10 reset state");
    conv2(8'd127, 8'h80, "R10 reset limits never trip");
    // same-cycle write and conversion use the old limit
    cyc(1, 8'd100, 0, 0, 0, 1, 0, 1, 8'd50, "R11 old limit in write cycle");
    wlim(0, 0, 8'd10, "R11 write ch0 low");
    wlim(1, 1, 8'd60, "R11 write ch1 high");
    wlim(1, 0, 8'hEC, "R11 write ch1 low");
    conv2(8'd20, 8'd0, "R11 in range");
    conv2(8'd50, 8'd0, "R1 equal high does not trip");
    conv2(8'd51, 8'd0, "R1 high excursion");
    rdp("R3 read clears");
    conv2(8'd70, 8'd0, "R4 same limit no new irq");
    rdp("R3 read clears");
    conv2(8'd10, 8'd0, "R2 equal low does not trip");
    conv2(8'd5, 8'd0, "R5 opposite crossing fires");
    rdp("R3 read clears");
    conv2(8'd5, 8'd0, "R4 still low no irq");
    rdp("R3 read clears");
    wlim(0, 1, 8'd50, "R6 other limit write");
    conv2(8'd5, 8'd0, "R6 other limit no rearm");
    rdp("R3 read clears");
    wlim(0, 0, 8'd10, "R6 rewrite recorded limit");
    conv2(8'd5, 8'd0, "R6 rearmed fires");
    rdp("R3 read clears");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 other source pulse");
    conv2(8'd5, 8'd0, "R7 rearmed by other source");
    rdp("R3 read clears");
    conv2(8'd5, 8'hE0, "R7 sibling fires");
    rdp("R3 read clears");
    conv2(8'd5, 8'hE0, "R7 rearmed by sibling");
    rdp("R3 read clears");
    mask = 4'b1010;
    conv2(8'd5, 8'hE0, "R8 masked low sets status only");
    mask = 4'b0000;
    cyc(1, 8'd5, 8'hE0, 1, 0, 0, 0, 0, 0, "R9 conversion and read together");
    cyc(1, 8'd90, 8'd0, 0, 0, 1, 0, 1, 8'd20, "R7 fire with write same cycle");
    rdp("R3 read clears");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, b, d;
      a = 8'($urandom_range(0, 120) - 60);
      b = 8'($urandom_range(0, 120) - 60);
      d = 8'($urandom_range(0, 100) - 40);
      if ($urandom_range(0, 15) == 0) mask = 4'($urandom);
      cyc($urandom_range(0, 1) == 1, a, b, $urandom_range(0, 3) == 0,
          $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0,
          $urandom_range(0, 1), $urandom_range(0, 1) == 1, d,
          "random R1 R2 R3 R4 R5 R6 R7 R8 R9 R11");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule